// File: doc/BRIEF.md
# Interrupt / Square-Wave Pin Controller

This block decides what a single shared, open-drain output pin does. The pin carries either a programmable square wave, taken from a divider chain clocked by the 32.768 kHz timekeeping clock, or an alarm interrupt. The alarm interrupt is either a fixed-width pulse or a level that follows the alarm status flag. A selected frequency always owns the pin ahead of the alarm. When the system runs from its backup battery and the battery-disable input is set, the pin is released entirely.

The block runs from the 32.768 kHz clock. It takes a 4-bit rate selection, an alarm-mode bit, the alarm match event and the alarm status flag. Its output is a pull-low enable for the external open-drain driver: 1 pulls the pin low, 0 releases it. Alarm comparison and the registers that hold the control bits live outside the block.

Top module: `irq_fout_ctrl`

## Requirements
- R1: While reset is high the pin is released. After reset the active rate code is 1, so the pin toggles at the clock rate until the first rate change takes effect.
- R2: The divider counts the clock edges since reset was released, and "edge n" is the n-th edge after release. With active rate code c in 2..7, the pin is pulled low after edge n exactly when bit t of n is 0. The value of t is 2, 4, 8, 9, 10, 11 for c = 2, 3, 4, 5, 6, 7, which gives 4096, 1024, 64, 32, 16 and 8 Hz.
- R3: With active rate code 1 (32768 Hz), the pin is pulled low during the high phase of the clock and released during its low phase.
- R4: A new rate selection becomes active only at edges whose number is a multiple of 4096. Every output rate has a phase boundary there, so no half period is ever cut short.
- R5: Selection values 0 and 8 to 15 (bit 3 set) turn the square wave off, and the pin then belongs to the alarm function.
- R6: While a square-wave rate is active, the alarm flag and the alarm event have no effect on the pin.
- R7: With the alarm mode bit at 1 and no rate active, a match event sampled at edge E pulls the pin low after edges E through E+PULSE_CYCLES-1 (8192 cycles, 250 ms by default) and releases it after edge E+PULSE_CYCLES.
- R8: With the alarm mode bit at 0 and no rate active, the pin after each edge equals the alarm status flag sampled at that edge.
- R9: When both the battery-disable input and the on-battery indicator are 1, the pin is released in every mode. This takes effect for the square wave by the next clock phase and for the alarm output after the next edge. If either input is 0, the pin behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz timekeeping clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fsel_i | input | 4 | Requested square-wave rate code |
| im_i | input | 1 | Alarm mode: 1 = fixed pulse, 0 = level following the flag |
| bat_dis_i | input | 1 | Release the pin while running on battery |
| on_bat_i | input | 1 | System is running from the backup battery |
| alarm_evt_i | input | 1 | One-cycle alarm match event |
| alarm_flag_i | input | 1 | Alarm status flag |
| pin_pull_o | output | 1 | 1 pulls the open-drain pin low |

## Verification
The bench builds the block with its default parameters: a 12-bit divider and an 8192-cycle pulse. The run therefore covers the real 4096-cycle change boundary, the slowest 8 Hz tap with its 2048-cycle half period, and a full-length alarm pulse, including its exact first and last low cycles. The expected pin levels come from edge counts since reset. This lets the bench place each check precisely on both sides of a rate change, of the pulse ends and of the battery gate.

// File: rtl/ifo_pkg.sv
package ifo_pkg;

    localparam int unsigned SEL_W  = 4;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned TAP_W  = 4;
    localparam int unsigned NCODES = 1 << CODE_W;

    typedef logic [SEL_W-1:0]  fsel_req_t;
    typedef logic [CODE_W-1:0] fcode_t;
    typedef logic [TAP_W-1:0]  tap_t;

    localparam fcode_t CODE_OFF  = fcode_t'(0);
    localparam fcode_t CODE_FAST = fcode_t'(1);

    // Which function owns the pin in a given cycle
    typedef enum logic [1:0] {
        PIN_IDLE,
        PIN_FAST,
        PIN_DIV,
        PIN_ALARM
    } pin_src_t;

    typedef struct packed {
        pin_src_t src;
        logic     level;
    } pin_drive_t;

    // Out-of-range requests (bit 3 set) collapse to "off"
    function automatic fcode_t fsel_clean(fsel_req_t req);
        if (req[SEL_W-1]) return CODE_OFF;
        return fcode_t'(req[CODE_W-1:0]);
    endfunction

    function automatic logic fcode_divided(fcode_t c);
        return c > CODE_FAST;
    endfunction

    // Divider bit whose value gives the half period for each rate code
    function automatic tap_t fcode_tap(fcode_t c);
        case (c)
            fcode_t'(2): return tap_t'(2);
            fcode_t'(3): return tap_t'(4);
            fcode_t'(4): return tap_t'(8);
            fcode_t'(5): return tap_t'(9);
            fcode_t'(6): return tap_t'(10);
            default:     return tap_t'(11);
        endcase
    endfunction

endpackage

// File: rtl/ifo_divider.sv
module ifo_divider
    import ifo_pkg::*;
#(
    parameter int unsigned CNT_W    = 12,
    parameter fcode_t      RST_CODE = CODE_FAST
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  fsel_req_t        fsel_i,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output fcode_t           code_nxt_o,
    output fcode_t           code_q_o
);

    logic [CNT_W-1:0] cnt_q;
    fcode_t           code_q;
    logic             wrap;

    // All divider taps restart their phase together when the counter wraps
    assign wrap = &cnt_q;

    always_comb begin
        cnt_nxt_o  = cnt_q + 1'b1;
        code_nxt_o = wrap ? fsel_clean(fsel_i) : code_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            code_q <= RST_CODE;
        end else begin
            cnt_q  <= cnt_nxt_o;
            code_q <= code_nxt_o;
        end
    end

    assign code_q_o = code_q;

endmodule

// File: rtl/ifo_pulse_timer.sv
module ifo_pulse_timer #(
    parameter int unsigned PULSE_CYCLES = 8192
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fire_i,
    output logic busy_nxt_o
);

    localparam int unsigned TW = $clog2(PULSE_CYCLES + 1);

    logic [TW-1:0] left_q;
    logic [TW-1:0] left_nxt;

    // A new event restarts the full window
    always_comb begin
        if (fire_i)
            left_nxt = TW'(PULSE_CYCLES);
        else if (left_q != '0)
            left_nxt = left_q - 1'b1;
        else
            left_nxt = '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) left_q <= '0;
        else       left_q <= left_nxt;
    end

    assign busy_nxt_o = (left_nxt != '0);

endmodule

// File: rtl/ifo_pin_arb.sv
module ifo_pin_arb
    import ifo_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  fcode_t           code_nxt_i,
    input  fcode_t           code_q_i,
    input  logic             im_i,
    input  logic             flag_i,
    input  logic             pulse_nxt_i,
    input  logic             gate_i,
    output logic             slow_pull_o,
    output logic             pin_pull_o
);

    logic [NCODES-1:0] wave_by_code;
    pin_drive_t        drv;
    logic              slow_q;
    logic              fast_en_q;

    // One pull level per rate code, taken from the divider's next value
    for (genvar c = 0; c < NCODES; c++) begin : g_wave
        if (c > 1) begin : g_div
            assign wave_by_code[c] = ~cnt_nxt_i[fcode_tap(fcode_t'(c))];
        end else begin : g_none
            assign wave_by_code[c] = 1'b0;
        end
    end

    always_comb begin
        drv = '{src: PIN_IDLE, level: 1'b0};
        if (gate_i) begin
            drv = '{src: PIN_IDLE, level: 1'b0};
        end else if (code_nxt_i == CODE_FAST) begin
            drv = '{src: PIN_FAST, level: 1'b0};
        end else if (fcode_divided(code_nxt_i)) begin
            drv = '{src: PIN_DIV, level: wave_by_code[code_nxt_i]};
        end else begin
            drv = '{src: PIN_ALARM, level: (im_i ? pulse_nxt_i : flag_i)};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) slow_q <= 1'b0;
        else       slow_q <= ((drv.src == PIN_DIV) || (drv.src == PIN_ALARM)) && drv.level;
    end

    // Full-rate enable changes only while the clock is low, so the gated
    // clock never produces a partial high phase
    always_ff @(negedge clk_i) begin
        if (rst_i) fast_en_q <= 1'b0;
        else       fast_en_q <= (code_q_i == CODE_FAST) && !gate_i;
    end

    assign slow_pull_o = slow_q;
    assign pin_pull_o  = (clk_i & fast_en_q) | slow_q;

endmodule

// File: rtl/irq_fout_ctrl.sv
module irq_fout_ctrl
    import ifo_pkg::*;
#(
    parameter int unsigned CNT_W        = 12,
    parameter int unsigned PULSE_CYCLES = 8192
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [3:0] fsel_i,
    input  logic       im_i,
    input  logic       bat_dis_i,
    input  logic       on_bat_i,
    input  logic       alarm_evt_i,
    input  logic       alarm_flag_i,
    output logic       pin_pull_o
);

    logic [CNT_W-1:0] cnt_nxt;
    fcode_t           code_nxt;
    fcode_t           code_q;
    logic             pulse_nxt;
    logic             gate;
    logic             slow_pull;

    assign gate = bat_dis_i & on_bat_i;

    ifo_divider #(
        .CNT_W    (CNT_W),
        .RST_CODE (CODE_FAST)
    ) u_div (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .fsel_i     (fsel_i),
        .cnt_nxt_o  (cnt_nxt),
        .code_nxt_o (code_nxt),
        .code_q_o   (code_q)
    );

    ifo_pulse_timer #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_pulse (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .fire_i     (alarm_evt_i),
        .busy_nxt_o (pulse_nxt)
    );

    ifo_pin_arb #(
        .CNT_W (CNT_W)
    ) u_arb (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cnt_nxt_i   (cnt_nxt),
        .code_nxt_i  (code_nxt),
        .code_q_i    (code_q),
        .im_i        (im_i),
        .flag_i      (alarm_flag_i),
        .pulse_nxt_i (pulse_nxt),
        .gate_i      (gate),
        .slow_pull_o (slow_pull),
        .pin_pull_o  (pin_pull_o)
    );

endmodule

// File: rtl/irq_fout_ctrl_chk.sv
module irq_fout_ctrl_chk
    import ifo_pkg::*;
#(
    parameter int unsigned CNT_W        = 12,
    parameter int unsigned PULSE_CYCLES = 8192
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic [3:0] fsel_i,
    input logic       im_i,
    input logic       bat_dis_i,
    input logic       on_bat_i,
    input logic       alarm_evt_i,
    input logic       alarm_flag_i,
    input fcode_t     code_q,
    input logic       slow_pull
);

    logic [CNT_W-1:0] edge_cnt;
    int unsigned      plen;
    logic             own_q;
    logic             own_qq;
    logic             gated;
    logic             req_off;
    logic             alarm_owns;

    assign gated      = bat_dis_i && on_bat_i;
    assign req_off    = (fsel_i[2:0] == 3'd0) || fsel_i[3];
    assign alarm_owns = im_i && !gated && (code_q == CODE_OFF) && req_off;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            edge_cnt <= '0;
            plen     <= 0;
            own_q    <= 1'b0;
            own_qq   <= 1'b0;
        end else begin
            edge_cnt <= edge_cnt + 1'b1;
            if (alarm_evt_i)          plen <= 0;
            else if (plen < 32'hFFFF) plen <= plen + 1;
            own_q  <= alarm_owns;
            own_qq <= own_q;
        end
    end

    AST_SEL_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(code_q) |-> (edge_cnt == '0));                                  // R4

    AST_BAD_SEL_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        ((&edge_cnt) && fsel_i[3]) |=> (code_q == CODE_OFF));                    // R5

    AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(slow_pull) && own_q && own_qq) |-> (plen == PULSE_CYCLES));       // R7

    AST_LEVEL_FOLLOWS_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (!im_i && !gated && (code_q == CODE_OFF) && req_off)
            |=> (slow_pull == $past(alarm_flag_i)));                             // R8

    AST_BATTERY_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        gated |=> !slow_pull);                                                   // R9

endmodule

bind irq_fout_ctrl irq_fout_ctrl_chk #(
    .CNT_W        (CNT_W),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .fsel_i       (fsel_i),
    .im_i         (im_i),
    .bat_dis_i    (bat_dis_i),
    .on_bat_i     (on_bat_i),
    .alarm_evt_i  (alarm_evt_i),
    .alarm_flag_i (alarm_flag_i),
    .code_q       (code_q),
    .slow_pull    (slow_pull)
);

// File: tb/irq_fout_ctrl_test.sv
module irq_fout_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] fsel;
    logic       im, bat_dis, on_bat, evt, flag;
    logic       pull;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;

    typedef struct {
        int    at;
        bit    ph;     // 0: clock high phase, 1: clock low phase
        logic  exp;
        string tag;
    } exp_t;

    exp_t q[$];

    irq_fout_ctrl uut (
        .clk_i        (clk),
        .rst_i        (rst),
        .fsel_i       (fsel),
        .im_i         (im),
        .bat_dis_i    (bat_dis),
        .on_bat_i     (on_bat),
        .alarm_evt_i  (evt),
        .alarm_flag_i (flag),
        .pin_pull_o   (pull)
    );

    always #5 clk = ~clk;

    // Edge number since reset release
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(string tag, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s at edge %0d: actual %0b expected %0b", tag, cyc, act, exp);
        end
    endtask

    task automatic push(int at, bit ph, logic exp, string tag);
        exp_t it;
        it.at = at; it.ph = ph; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    // Pull level for a divided rate: low when bit b of edge number is 0
    function automatic logic div_pull(int n, int b);
        return ((n >> b) & 1) == 0;
    endfunction

    task automatic goto_edge(int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic drain(bit ph);
        while (q.size() > 0 &&
               (q[0].at < cyc || (q[0].at == cyc && q[0].ph <= ph))) begin
            exp_t it = q.pop_front();
            if (it.at != cyc || it.ph != ph) begin
                nchk++;
                nfail++;
                $display("FAIL %s: sample for edge %0d missed, actual none expected %0b",
                         it.tag, it.at, it.exp);
            end else begin
                check(it.tag, pull, it.exp);
            end
        end
    endtask

    // Monitor: compares the pin in both clock phases against queued items
    initial begin
        forever begin
            @(posedge clk);
            #3 drain(1'b0);
            #5 drain(1'b1);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #3_000_000;
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1; fsel = 4'd1; im = 1'b0; bat_dis = 1'b0; on_bat = 1'b0;
        evt = 1'b0; flag = 1'b0;
        repeat (3) @(posedge clk);
        #3 check("R1 reset high phase", pull, 1'b0);
        #5 check("R1 reset low phase", pull, 1'b0);
        @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R3: full-rate wave straight after reset
        for (int n = 1; n <= 6; n++) begin
            push(n, 1'b0, 1'b1, "R1_R3 fast high");
            push(n, 1'b1, 1'b0, "R1_R3 fast low");
        end

        // R2 / R4: 4096 Hz requested early, active only from edge 4096
        goto_edge(4000);
        fsel = 4'd2;
        push(4090, 1'b0, 1'b1, "R4 still fast high");
        push(4090, 1'b1, 1'b0, "R4 still fast low");
        for (int n = 4097; n <= 4104; n++)
            push(n, 1'b1, div_pull(n, 2), "R2 4096Hz");
        push(4200, 1'b1, div_pull(4200, 2), "R2 4096Hz later");

        // R2 / R6: 8 Hz from edge 8192, alarm flag ignored
        goto_edge(4300);
        fsel = 4'd7;
        push(8192, 1'b1, 1'b1, "R2 8Hz first half");
        push(9000, 1'b1, 1'b1, "R2 8Hz mid half");
        push(10239, 1'b1, 1'b1, "R2 8Hz last low");
        push(10240, 1'b1, 1'b0, "R2 8Hz release");
        goto_edge(10250);
        flag = 1'b1;
        push(10300, 1'b1, 1'b0, "R6 flag masked");
        push(11000, 1'b1, 1'b0, "R6 flag masked later");

        // R5 / R8: code 9 is off, pin follows the flag
        goto_edge(11100);
        fsel = 4'd9;
        push(12287, 1'b1, 1'b0, "R6 before boundary");
        push(12288, 1'b1, 1'b1, "R5 code 9 off");
        push(12400, 1'b1, 1'b1, "R8 flag held");
        goto_edge(12400);
        flag = 1'b0;
        push(12401, 1'b1, 1'b0, "R8 flag cleared");

        // R7: fixed-width pulse
        goto_edge(12410);
        im = 1'b1;
        push(12499, 1'b1, 1'b0, "R7 before event");
        push(12500, 1'b1, 1'b1, "R7 first pulse cycle");
        push(16000, 1'b1, 1'b1, "R7 mid pulse");
        push(20691, 1'b1, 1'b1, "R7 last pulse cycle");
        push(20692, 1'b1, 1'b0, "R7 pulse end");
        goto_edge(12499);
        evt = 1'b1;
        goto_edge(12500);
        evt = 1'b0;

        // R9: gate on the level alarm
        goto_edge(20800);
        im = 1'b0; flag = 1'b1; on_bat = 1'b1; bat_dis = 1'b1;
        push(20805, 1'b1, 1'b0, "R9 gated alarm");
        goto_edge(20810);
        bat_dis = 1'b0;
        push(20812, 1'b1, 1'b1, "R9 battery not disabled");
        goto_edge(20820);
        on_bat = 1'b0; bat_dis = 1'b1;
        push(20825, 1'b1, 1'b1, "R9 disable off battery");
        goto_edge(20830);
        flag = 1'b0; bat_dis = 1'b0;
        push(20835, 1'b1, 1'b0, "R8 flag low");

        // R3 / R9: back to full rate, then gated
        goto_edge(20900);
        fsel = 4'd1;
        push(24580, 1'b0, 1'b1, "R3 fast high");
        push(24580, 1'b1, 1'b0, "R3 fast low");
        goto_edge(24600);
        on_bat = 1'b1; bat_dis = 1'b1;
        push(24605, 1'b0, 1'b0, "R9 gated fast high");
        goto_edge(24610);
        on_bat = 1'b0; bat_dis = 1'b0;
        push(24612, 1'b0, 1'b1, "R9 ungated fast high");
        push(24612, 1'b1, 1'b0, "R9 ungated fast low");

        goto_edge(24620);
        if (q.size() != 0) begin
            nchk++;
            nfail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
        end
        finish_run();
    end

endmodule